// File: doc/BRIEF.md
# Timer Kill Input Controller

This block handles the kill input of a PWM or timer slice. A kill line arriving from outside the chip is asynchronous. The block has two ways of acting on it. A static mode input selects which one is active.

In **disable mode**, the block samples the kill line on falling edges of the system clock. Once sampled, the kill clears the timer's enable flag. Sampling on the falling edge leaves half a cycle of margin before a rising-edge register write that sets the enable again. Separately, the timer's output bits are forced low through a purely combinational path. That path acts as soon as the raw kill line rises and does not wait for the synchronizer.

In **reload mode**, the block samples the kill line on rising edges of the block clock and holds the synchronized level high for one extra block cycle. While that stretched level is high, the block raises a strobe that reloads the count register on every rising block edge. One block cycle after the level drops, it raises a single-cycle strobe that reloads the multi-shot counter. The counter itself lives outside this block. The only data path here is the gated output, a plain combinational pass of a control level, so it carries no valid/ready handshake and nothing in the block applies back-pressure.

Top module: `tkc_kill_ctrl`

## Requirements
- R1: While rst_n is low, en_o, kill_sync_o, ld_count_o, ld_shot_o and out_o are all 0.
- R2: In disable mode (mode_i = 0), kill_sync_o equals the value kill_in had at the second-most-recent falling edge of sys_clk (two-stage synchronizer on falling edges).
- R3: In disable mode, at a rising edge of sys_clk where kill_sync_o is 1, en_o is cleared to 0, and a simultaneous en_wr is ignored.
- R4: In disable mode, out_o is all zeros whenever kill_in is 1, with no clock edge needed.
- R5: At a rising edge of sys_clk with en_wr = 1 and no synced disable-mode kill, en_o takes en_wdata. Otherwise en_o holds its value. out_o equals out_in when en_o is 1 and no blanking applies, and is zero when en_o is 0.
- R6: In reload mode (mode_i = 1), after rising block-clock edge n, kill_sync_o = k[n-1] OR k[n-2], where k[j] is kill_in sampled at rising edge j. This is a two-stage synchronizer with a one-cycle stretch.
- R7: In reload mode, ld_count_o is high exactly when the stretched synced kill is high.
- R8: In reload mode, ld_shot_o is high for exactly one block cycle, the cycle after the stretched synced kill falls.
- R9: In reload mode, kill does not clear en_o and does not blank out_o. In disable mode, ld_count_o and ld_shot_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; the enable flag and disable-mode synchronizer run on it |
| blk_clk | input | 1 | Block clock; the reload-mode synchronizer and strobes run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Kill mode: 0 = disable, 1 = reload; static during operation |
| kill_in | input | 1 | Asynchronous kill request, active high |
| en_wr | input | 1 | Write strobe for the enable flag (sys_clk domain) |
| en_wdata | input | 1 | Value written to the enable flag |
| out_in | input | W | Raw timer output bits |
| en_o | output | 1 | Timer enable flag |
| kill_sync_o | output | 1 | Synchronized kill of the active mode |
| ld_count_o | output | 1 | Count-register reload strobe (block clock) |
| ld_shot_o | output | 1 | Multi-shot counter reload strobe (block clock) |
| out_o | output | W | Gated timer output bits |

## Verification
The bench builds the block with W = 4. That makes the immediate blanking visible on a multi-bit output rather than a single wire. SYNC_STAGES = 2 and STRETCH = 1 stay at their defaults, so the bench's edge-counting model of the two-edge latency and the one-cycle extension applies directly. With these values, random kill pulses as short as one block cycle reach the corner where a new kill arrives inside the stretch window. In that case the shot strobe must not appear until the merged level finally drops.

// File: rtl/tkc_pkg.sv
`timescale 1ns/1ps
package tkc_pkg;
  typedef enum logic {
    KILL_DISABLE = 1'b0,
    KILL_RELOAD  = 1'b1
  } kill_mode_e;
endpackage

// File: rtl/tkc_sync.sv
`timescale 1ns/1ps
module tkc_sync #(
  parameter int STAGES    = 2,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tkc_enable.sv
`timescale 1ns/1ps
module tkc_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr,
  input  logic wdata,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= 1'b0;
    else if (clr) en <= 1'b0;
    else if (wr)  en <= wdata;
  end
endmodule

// File: rtl/tkc_reload_seq.sv
`timescale 1ns/1ps
module tkc_reload_seq #(
  parameter int STRETCH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic held_o,
  output logic ld_count_o,
  output logic ld_shot_o
);
  logic [STRETCH-1:0] tail;
  logic               held_q;

  generate
    if (STRETCH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tail <= '0;
        else        tail <= sync_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tail <= '0;
        else        tail <= {tail[STRETCH-2:0], sync_in};
      end
    end
  endgenerate

  assign held_o = sync_in | (|tail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_o;
  end

  assign ld_count_o = held_o;
  assign ld_shot_o  = held_q & ~held_o;
endmodule

// File: rtl/tkc_kill_ctrl.sv
`timescale 1ns/1ps
module tkc_kill_ctrl #(
  parameter int W           = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 1
) (
  input  logic         sys_clk,
  input  logic         blk_clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         kill_in,
  input  logic         en_wr,
  input  logic         en_wdata,
  input  logic [W-1:0] out_in,
  output logic         en_o,
  output logic         kill_sync_o,
  output logic         ld_count_o,
  output logic         ld_shot_o,
  output logic [W-1:0] out_o
);
  import tkc_pkg::*;

  kill_mode_e mode;
  logic       dis_mode, rel_mode;
  logic       dis_sync, rel_sync, rel_held;
  logic       blank;

  assign mode     = kill_mode_e'(mode_i);
  assign dis_mode = (mode == KILL_DISABLE);
  assign rel_mode = (mode == KILL_RELOAD);

  tkc_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_dis_sync (
    .clk(sys_clk), .rst_n(rst_n), .d(kill_in & dis_mode), .q(dis_sync)
  );

  tkc_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_rel_sync (
    .clk(blk_clk), .rst_n(rst_n), .d(kill_in & rel_mode), .q(rel_sync)
  );

  tkc_enable u_enable (
    .clk(sys_clk), .rst_n(rst_n), .clr(dis_sync), .wr(en_wr),
    .wdata(en_wdata), .en(en_o)
  );

  tkc_reload_seq #(.STRETCH(STRETCH)) u_reload (
    .clk(blk_clk), .rst_n(rst_n), .sync_in(rel_sync), .held_o(rel_held),
    .ld_count_o(ld_count_o), .ld_shot_o(ld_shot_o)
  );

  assign kill_sync_o = rel_mode ? rel_held : dis_sync;
  assign blank       = kill_in & dis_mode;
  assign out_o       = out_in & {W{en_o & ~blank & rst_n}};
endmodule

// File: rtl/tkc_kill_ctrl_chk.sv
`timescale 1ns/1ps
module tkc_kill_ctrl_chk #(
  parameter int W = 2
) (
  input logic         sys_clk,
  input logic         blk_clk,
  input logic         rst_n,
  input logic         mode_i,
  input logic         kill_in,
  input logic         en_o,
  input logic         kill_sync_o,
  input logic         ld_count_o,
  input logic         ld_shot_o,
  input logic [W-1:0] out_o
);
  // R3: a synced kill in disable mode leaves the enable flag clear
  p_kill_clears_en_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!mode_i && kill_sync_o) |=> !en_o);

  // R4: raw kill blanks the output in disable mode
  p_blank_out_r4: assert property (@(negedge sys_clk) disable iff (!rst_n)
    (!mode_i && kill_in) |-> (out_o == '0));

  // R6: stretched synced kill stays high at least two block cycles
  p_stretch_r6: assert property (@(posedge blk_clk) disable iff (!rst_n)
    (mode_i && $rose(kill_sync_o)) |=> kill_sync_o);

  // R8: shot strobe follows a count strobe that has just ended
  p_shot_after_count_r8: assert property (@(posedge blk_clk) disable iff (!rst_n)
    (mode_i && ld_shot_o) |-> (!ld_count_o && $past(ld_count_o)));

  // R8: shot strobe lasts a single block cycle
  p_shot_single_r8: assert property (@(posedge blk_clk) disable iff (!rst_n)
    ld_shot_o |=> !ld_shot_o);

  // R9: no reload strobes in disable mode
  p_idle_strobes_r9: assert property (@(posedge blk_clk) disable iff (!rst_n)
    !mode_i |-> (!ld_count_o && !ld_shot_o));
endmodule

bind tkc_kill_ctrl tkc_kill_ctrl_chk #(.W(W)) u_chk (
  .sys_clk(sys_clk), .blk_clk(blk_clk), .rst_n(rst_n), .mode_i(mode_i),
  .kill_in(kill_in), .en_o(en_o), .kill_sync_o(kill_sync_o),
  .ld_count_o(ld_count_o), .ld_shot_o(ld_shot_o), .out_o(out_o)
);

// File: tb/tkc_kill_ctrl_bench.sv
`timescale 1ns/1ps
module tkc_kill_ctrl_bench;
  localparam int W = 4;

  logic sys_clk = 1'b0, blk_clk = 1'b0, rst_n = 1'b0;
  logic mode_i = 1'b0, kill_in = 1'b0, en_wr = 1'b0, en_wdata = 1'b0;
  logic [W-1:0] out_in = '0;
  logic en_o, kill_sync_o, ld_count_o, ld_shot_o;
  logic [W-1:0] out_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  tkc_kill_ctrl #(.W(W)) u_tkc_kill_ctrl (
    .sys_clk(sys_clk), .blk_clk(blk_clk), .rst_n(rst_n), .mode_i(mode_i),
    .kill_in(kill_in), .en_wr(en_wr), .en_wdata(en_wdata), .out_in(out_in),
    .en_o(en_o), .kill_sync_o(kill_sync_o), .ld_count_o(ld_count_o),
    .ld_shot_o(ld_shot_o), .out_o(out_o)
  );

  always #2.5 sys_clk = ~sys_clk;            // 200 MHz
  initial begin #1.25; forever #5 blk_clk = ~blk_clk; end

  // bench-side models built from the requirements
  logic [1:0] ks_sys;                        // R2 falling-edge samples
  logic       en_m;                          // R3/R5
  logic [3:0] kh;                            // R6 rising block-edge samples

  always @(negedge sys_clk or negedge rst_n)
    if (!rst_n) ks_sys <= '0; else ks_sys <= {ks_sys[0], kill_in & ~mode_i};
  always @(posedge sys_clk or negedge rst_n)
    if (!rst_n) en_m <= 1'b0;
    else if (!mode_i && ks_sys[1]) en_m <= 1'b0;
    else if (en_wr) en_m <= en_wdata;
  always @(posedge blk_clk or negedge rst_n)
    if (!rst_n) kh <= '0; else kh <= {kh[2:0], kill_in & mode_i};

  function automatic logic exp_held();
    return kh[1] | kh[2];
  endfunction
  function automatic logic exp_shot();
    return (kh[2] | kh[3]) & ~(kh[1] | kh[2]);
  endfunction
  function automatic logic [W-1:0] exp_out();
    return (en_m && !(kill_in && !mode_i)) ? out_in : '0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic do_reset(input logic m);
    @(negedge sys_clk); #1;
    rst_n = 1'b0; mode_i = m; kill_in = 1'b0; en_wr = 1'b0;
    #4;
    check("R1 en", W'(en_o), '0);
    check("R1 sync", W'(kill_sync_o), '0);
    check("R1 strobes", W'({ld_count_o, ld_shot_o}), '0);
    check("R1 out", out_o, '0);
    #7 rst_n = 1'b1;
  endtask

  task automatic sys_step(input logic k, input logic wr, input logic wd, input logic [W-1:0] oi);
    @(negedge sys_clk); #1;
    kill_in = k; en_wr = wr; en_wdata = wd; out_in = oi;
    @(posedge sys_clk); #1;
    check("R2 kill_sync", W'(kill_sync_o), W'(ks_sys[1]));
    check("R3/R5 en", W'(en_o), W'(en_m));
    check("R4/R5 out", out_o, exp_out());
    check("R9 strobes idle", W'({ld_count_o, ld_shot_o}), '0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    out_in = 4'hA;
    do_reset(1'b0);

    // disable mode: directed
    sys_step(1'b0, 1'b1, 1'b1, 4'hF);          // R5 set enable
    sys_step(1'b0, 1'b0, 1'b0, 4'h6);          // R5 pass-through
    // R4: blanking before any sync edge
    @(negedge sys_clk); #1; kill_in = 1'b1; out_in = 4'hF; #0.5;
    check("R4 immediate blank", out_o, '0);
    check("R2 not yet synced", W'(kill_sync_o), '0);
    sys_step(1'b1, 1'b0, 1'b0, 4'hF);
    sys_step(1'b1, 1'b1, 1'b1, 4'hF);          // R3 write during kill ignored
    sys_step(1'b0, 1'b0, 1'b0, 4'hF);
    sys_step(1'b0, 1'b0, 1'b0, 4'hF);
    sys_step(1'b0, 1'b1, 1'b1, 4'h9);          // R5 re-enable after kill
    sys_step(1'b0, 1'b0, 1'b0, 4'h9);

    // disable mode: random
    for (int i = 0; i < 400; i++)
      sys_step(($urandom % 4) == 0, ($urandom % 3) == 0, $urandom % 2, W'($urandom));

    // reload mode
    do_reset(1'b1);
    out_in = 4'h5;
    @(negedge sys_clk); #1; en_wr = 1'b1; en_wdata = 1'b1;
    @(negedge sys_clk); #1; en_wr = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge blk_clk);
      check("R6 held kill", W'(kill_sync_o), W'(exp_held()));
      check("R7 count strobe", W'(ld_count_o), W'(exp_held()));
      check("R8 shot strobe", W'(ld_shot_o), W'(exp_shot()));
      check("R9 en kept", W'(en_o), W'(1'b1));
      check("R9 out not blanked", out_o, out_in);
      #1;
      if (i < 40)       kill_in = (i >= 10 && i < 15);   // directed long pulse
      else if (i < 60)  kill_in = (i == 45) || (i == 47); // short pulses merging
      else              kill_in = ($urandom % 3) == 0;
      out_in = W'($urandom);
    end
    finish_run();
  end
endmodule